// File: doc/BRIEF.md
# Programmable Voltage Threshold Detect Controller

This block holds the digital control and event logic for a supply trip detector. Software programs an 8-bit control word through a simple write strobe and reads it back at any time. The word carries four things: the crossing direction, an enable, a 4-bit trip-level code and a read-only settled-reference status. The monitored voltage arrives as an unsigned digital sample. Each cycle it is compared with the trip level that the code selects. Codes 0 to 14 choose internal levels from a parameterised ladder. Code 15 uses an external level input in place of the ladder.

After the enable is set, a settling counter runs for a fixed number of cycles. The status bit comes up only when that count ends. No event can be raised before then. Once the block is settled and the trip condition holds, a sticky flag is set. The flag stays set until a dedicated clear strobe arrives. The interrupt request is the flag gated by an interrupt-enable input.

Top module: `vtd_ctrl`

## Requirements
- R1: Readback layout: bit 7 = direction, bit 6 = reserved, bit 5 = settled status, bit 4 = enable, bits 3:0 = trip code. A write sets direction, enable and code, and the new values read back from the following cycle.
- R2: With direction 1, an event occurs when sample >= trip level. With direction 0, an event occurs when sample <= trip level. Equality counts in both cases. The flag is set on the clock edge after the condition is seen.
- R3: Bit 6 always reads 0, and writing 1 to it has no effect.
- R4: The settled status bit is read-only. A write of 1 to bit 5 never changes what bit 5 reads back.
- R5: The settled bit reads 1 exactly SETTLE_CYCLES cycles after the write that changed the enable from 0 to 1. Rewriting enable=1 while already enabled does not restart the count.
- R6: The flag is never set while the settled bit is 0, even if the trip condition holds.
- R7: For codes c = 0..14 the trip level is LVL_BASE + c*LVL_STEP. Code 15 uses ext_level_i as the trip level.
- R8: After reset the control word reads 8'h05, and the flag and the interrupt request are 0.
- R9: A write that clears the enable makes the settled bit read 0 from the next cycle. It also restarts the settling count, and no events occur while disabled.
- R10: The flag is sticky. It is cleared only by a flag_clr_i pulse.
- R11: irq_o equals the flag AND irq_en_i, combinationally.
- R12: When the trip condition and flag_clr_i occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 8 | Control word write data |
| reg_rdata_o | output | 8 | Control word readback |
| sample_i | input | SAMPLE_W | Digitised monitored voltage |
| ext_level_i | input | SAMPLE_W | External trip level, used for code 15 |
| flag_clr_i | input | 1 | Sticky flag clear strobe |
| irq_en_i | input | 1 | Interrupt enable |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that reset is held long enough for the control word to take its 8'h05 state before checks begin. They take no position on the sample values, so any sample sequence is legal.

The bench drives every input on the falling edge. Its random phase mixes control writes, including writes with the reserved and status bits set, with samples, clear strobes and interrupt-enable toggles. A behavioural model predicts the readback, the flag and the request for every cycle.

// File: rtl/vtd_pkg.sv
package vtd_pkg;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned BIT_DIR  = 7;
  localparam int unsigned BIT_RSV  = 6;
  localparam int unsigned BIT_STB  = 5;
  localparam int unsigned BIT_EN   = 4;
  localparam logic [CODE_W-1:0] EXT_CODE   = 4'hF;
  localparam logic [CODE_W-1:0] RESET_CODE = 4'h5;

  typedef struct packed {
    logic              dir;
    logic              en;
    logic [CODE_W-1:0] code;
  } ctrl_t;
endpackage

// File: rtl/vtd_regs.sv
module vtd_regs
  import vtd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.dir  <= 1'b0;
      ctrl_q.en   <= 1'b0;
      ctrl_q.code <= RESET_CODE;
    end else if (we_i) begin
      // reserved and status bits of wdata are dropped here
      ctrl_q.dir  <= wdata_i[BIT_DIR];
      ctrl_q.en   <= wdata_i[BIT_EN];
      ctrl_q.code <= wdata_i[CODE_W-1:0];
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/vtd_settle.sv
module vtd_settle #(
  parameter int unsigned SETTLE_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic stable_o
);
  localparam int unsigned CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!stable_q) begin
      if (cnt_q == CNT_LAST) stable_q <= 1'b1;
      else                   cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign stable_o = stable_q;
endmodule

// File: rtl/vtd_trip.sv
module vtd_trip
  import vtd_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned LVL_BASE = 400,
  parameter int unsigned LVL_STEP = 40
) (
  input  logic [CODE_W-1:0]   code_i,
  input  logic                dir_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] ext_level_i,
  output logic                cond_o
);
  localparam int unsigned N_CODES = 1 << CODE_W;

  logic [SAMPLE_W-1:0] lvl_tab [N_CODES];
  logic [SAMPLE_W-1:0] thr;

  for (genvar g = 0; g < N_CODES; g++) begin : g_lvl
    if (g == N_CODES - 1) begin : g_ext
      assign lvl_tab[g] = ext_level_i;
    end else begin : g_int
      assign lvl_tab[g] = SAMPLE_W'(LVL_BASE + g * LVL_STEP);
    end
  end

  assign thr    = lvl_tab[code_i];
  assign cond_o = dir_i ? (sample_i >= thr) : (sample_i <= thr);
endmodule

// File: rtl/vtd_ctrl.sv
module vtd_ctrl
  import vtd_pkg::*;
#(
  parameter int unsigned SAMPLE_W      = 10,
  parameter int unsigned SETTLE_CYCLES = 64,
  parameter int unsigned LVL_BASE      = 400,
  parameter int unsigned LVL_STEP      = 40
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [7:0]          reg_wdata_i,
  output logic [7:0]          reg_rdata_o,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] ext_level_i,
  input  logic                flag_clr_i,
  input  logic                irq_en_i,
  output logic                flag_o,
  output logic                irq_o
);
  ctrl_t ctrl;
  logic  stable, cond, hit, flag_q;

  vtd_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .wdata_i(reg_wdata_i),
    .ctrl_o (ctrl)
  );

  vtd_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl.en),
    .stable_o(stable)
  );

  vtd_trip #(
    .SAMPLE_W(SAMPLE_W),
    .LVL_BASE(LVL_BASE),
    .LVL_STEP(LVL_STEP)
  ) u_trip (
    .code_i     (ctrl.code),
    .dir_i      (ctrl.dir),
    .sample_i   (sample_i),
    .ext_level_i(ext_level_i),
    .cond_o     (cond)
  );

  assign hit = ctrl.en & stable & cond;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= hit | (flag_q & ~flag_clr_i);
  end

  always_comb begin
    reg_rdata_o                   = '0;
    reg_rdata_o[BIT_DIR]          = ctrl.dir;
    reg_rdata_o[BIT_STB]          = stable & ctrl.en;
    reg_rdata_o[BIT_EN]           = ctrl.en;
    reg_rdata_o[CODE_W-1:0]       = ctrl.code;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/vtd_ctrl_chk.sv
module vtd_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] reg_rdata_o,
  input logic       flag_clr_i,
  input logic       irq_en_i,
  input logic       flag_o,
  input logic       irq_o
);
  assert_rsv_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[6] == 1'b0);

  assert_no_flag_unsettled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(reg_rdata_o[5]));

  assert_settled_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[4] |-> !reg_rdata_o[5]);

  assert_settle_while_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[5]) |-> $past(reg_rdata_o[4]));

  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);

  assert_irq_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (flag_o && irq_en_i));
endmodule

bind vtd_ctrl vtd_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_rdata_o(reg_rdata_o),
  .flag_clr_i (flag_clr_i),
  .irq_en_i   (irq_en_i),
  .flag_o     (flag_o),
  .irq_o      (irq_o)
);

// File: tb/vtd_ctrl_tb_top.sv
`timescale 1ns/1ps
module vtd_ctrl_tb_top;
  localparam int SW     = 10;
  localparam int SETTLE = 16;
  localparam int BASE   = 400;
  localparam int STEP   = 40;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [7:0]    reg_wdata_i = '0;
  logic [7:0]    reg_rdata_o;
  logic [SW-1:0] sample_i = SW'(1000);
  logic [SW-1:0] ext_level_i = '0;
  logic          flag_clr_i = 1'b0;
  logic          irq_en_i = 1'b0;
  logic          flag_o, irq_o;

  always #10 clk_i = ~clk_i;

  vtd_ctrl #(.SAMPLE_W(SW), .SETTLE_CYCLES(SETTLE), .LVL_BASE(BASE), .LVL_STEP(STEP)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .sample_i(sample_i), .ext_level_i(ext_level_i),
    .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i), .flag_o(flag_o), .irq_o(irq_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_dir = 0, m_en = 0, m_stable = 0, m_flag = 0;
  int m_code = 5, m_age = 0;

  function automatic int level(int code);
    return (code == 15) ? int'(ext_level_i) : BASE + code * STEP;
  endfunction

  function automatic bit trip();
    return m_dir ? (int'(sample_i) >= level(m_code)) : (int'(sample_i) <= level(m_code));
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_dir <= 0; m_en <= 0; m_code <= 5; m_age <= 0; m_stable <= 0; m_flag <= 0;
    end else begin
      if (reg_we_i) begin
        m_dir  <= reg_wdata_i[7];
        m_en   <= reg_wdata_i[4];
        m_code <= int'(reg_wdata_i[3:0]);
      end
      if (!m_en) begin
        m_age <= 0; m_stable <= 0;
      end else begin
        m_age <= m_age + 1;
        if (m_age + 1 >= SETTLE) m_stable <= 1;
      end
      if (m_en && m_stable && trip()) m_flag <= 1;
      else if (flag_clr_i)            m_flag <= 0;
    end
  end

  // per-cycle comparison, away from both edges
  always @(negedge clk_i) begin
    #5;
    if (rst_ni && !done) begin
      chk("R1 dir",      reg_rdata_o[7],   m_dir);
      chk("R3 reserved", reg_rdata_o[6],   0);
      chk("R5 settled",  reg_rdata_o[5],   m_en && m_stable);
      chk("R1 enable",   reg_rdata_o[4],   m_en);
      chk("R1 code",     reg_rdata_o[3:0], m_code);
      chk("R2 flag",     flag_o,           m_flag);
      chk("R11 irq",     irq_o,            m_flag && irq_en_i);
    end
  end

  task automatic wr(logic [7:0] d);
    @(negedge clk_i); reg_we_i = 1; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #45 rst_ni = 1;
    @(negedge clk_i); #6;
    chk("R8 reset word", reg_rdata_o, 8'h05);
    chk("R8 reset flag", flag_o, 0);

    // enable, dir=0, code 5 (level 600), sample high
    wr(8'h15);
    cyc(SETTLE - 1); #6;
    chk("R5 not yet settled", reg_rdata_o[5], 0);
    wr(8'h15);                                // rewrite, no restart
    #6;
    chk("R5 settled on time", reg_rdata_o[5], 1);
    chk("R6 no early flag", flag_o, 0);

    // equality at level 600 with dir=0
    @(negedge clk_i); sample_i = SW'(600);
    @(negedge clk_i); sample_i = SW'(1000); #6;
    chk("R2 equal falls", flag_o, 1);
    irq_en_i = 1; #1;
    chk("R11 irq on", irq_o, 1);
    cyc(3); #6;
    chk("R10 sticky", flag_o, 1);
    @(negedge clk_i); flag_clr_i = 1;
    @(negedge clk_i); flag_clr_i = 0; #6;
    chk("R10 cleared", flag_o, 0);

    // R12: condition and clear together
    @(negedge clk_i); sample_i = SW'(100); flag_clr_i = 1;
    @(negedge clk_i); flag_clr_i = 0; sample_i = SW'(1000); #6;
    chk("R12 set wins", flag_o, 1);
    @(negedge clk_i); flag_clr_i = 1;
    @(negedge clk_i); flag_clr_i = 0;

    // R3/R4: write reserved and status bits, still enabled
    wr(8'h75); #6;
    chk("R3 bit6 zero", reg_rdata_o[6], 0);
    chk("R4 status keeps 1", reg_rdata_o[5], 1);

    // R9: disable, then check that status is 0 and no events occur
    wr(8'h25); #6;
    chk("R9 settled drops", reg_rdata_o[5], 0);
    chk("R4 status write ignored", reg_rdata_o[5], 0);
    @(negedge clk_i); sample_i = SW'(0);
    cyc(3); #6;
    chk("R9 no event disabled", flag_o, 0);

    // R7: code 15 with dir=1 and external level 300
    @(negedge clk_i); ext_level_i = SW'(300); sample_i = SW'(299);
    wr(8'h9F);
    cyc(SETTLE + 2); #6;
    chk("R7 below ext level", flag_o, 0);
    @(negedge clk_i); sample_i = SW'(300);
    @(negedge clk_i); #6;
    chk("R7 ext level hit", flag_o, 1);
    @(negedge clk_i); flag_clr_i = 1; sample_i = SW'(0);
    @(negedge clk_i); flag_clr_i = 0;

    // R7: code 14 with dir=1, level 960
    wr(8'h9E);
    @(negedge clk_i); sample_i = SW'(959);
    @(negedge clk_i); #6;
    chk("R7 top level miss", flag_o, 0);
    @(negedge clk_i); sample_i = SW'(960);
    @(negedge clk_i); #6;
    chk("R7 top level hit", flag_o, 1);

    // random phase, checked every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      reg_we_i    = ($urandom_range(0, 19) == 0);
      reg_wdata_i = 8'($urandom) | (($urandom_range(0, 7) != 0) ? 8'h10 : 8'h00);
      sample_i    = SW'($urandom_range(300, 1023));
      ext_level_i = SW'($urandom_range(300, 1023));
      flag_clr_i  = ($urandom_range(0, 3) == 0);
      irq_en_i    = ($urandom_range(0, 1) == 1);
    end
    @(negedge clk_i); reg_we_i = 0; flag_clr_i = 0;
    cyc(2);
    finish_run();
  end
endmodule